// File: doc/BRIEF.md
# Effective-Address Generator

This block forms the operand location for one instruction operand of a 16/32-bit CISC processor. It takes a 6-bit addressing field, made of a 3-bit mode and a 3-bit register number, together with an operand size. It reads the 16-entry register file through a single combinational read port, where indices 0–7 are the data registers and 8–15 are the address registers. It pulls any 16-bit extension words it needs from a valid/ready stream. The result is a 32-bit address, an immediate operand, or the register contents. Alongside the result it reports an optional address-register write-back, the extra cycle cost, and a flag for a rejected field.

The sequencer pulses `start` while the block is idle. The block then steps through the states the mode needs: decode, one or two extension fetches, and an index read. It pulses `done` for one cycle with all results valid, and keeps them unchanged until the next operand completes. The caller performs the bus access and applies the write-back itself. The size encoding is 0 for byte, 1 for word and 2 for long; the value 3 acts as long.

Top module: `ea_gen`

## Requirements
- R1: Fields 0x00–0x0F are register direct. The result is the contents of register-file entry `field[3:0]`. No extension word is taken, the extra cost is 0 and there is no write-back.
- R2: Fields 0x10–0x27 are register indirect, post-increment and pre-decrement through address register `field[2:0]`. The step is 1, 2 or 4 bytes for byte, word or long. Post-increment yields the old register value and writes back that value plus the step. Pre-decrement yields the register value minus the step and writes back the same value. Plain indirect does no write-back. The write-back index is 8 plus `field[2:0]`.
- R3: A byte-sized post-increment or pre-decrement through address register 7 steps by 2.
- R4: Fields 0x28–0x2F take one extension word, sign-extend it and add it to the address register.
- R5: The indexed forms are fields 0x30–0x37, with the address register as base, and field 0x3B, with `pc_in` as base. Each takes one brief word. Bits 15:12 of that word give the register-file index of the index register. Bit 11 set means the full 32-bit index is used; bit 11 clear means the sign-extended low 16 bits are used. Bits 7:0 are a signed displacement. The result is base + index + displacement.
- R6: Field 0x38 takes one word and sign-extends it. Field 0x39 takes two words, and the first word becomes bits 31:16.
- R7: Field 0x3A adds the sign-extended extension word to `pc_in`, where `pc_in` is the address of that extension word.
- R8: Field 0x3C is an immediate. Byte size takes one word and sign-extends its bits 7:0. Word size takes one word and sign-extends it. Long size takes two words, high word first.
- R9: The extra cost for byte/word versus long is as follows: indirect and post-increment 4/8; pre-decrement 6/10; displacement forms and absolute short 8/12; indexed forms 10/14; absolute long 12/16; immediate 4/8.
- R10: A field is rejected in three cases: it is above 0x3C; it is 0x3C with `is_dest` set; or `addr_only` is set and the field is register direct, post-increment, pre-decrement or immediate. A rejected field completes with `illegal`=1, result 0, cost 0, no write-back and no extension word taken.
- R11: `done` is high for exactly one cycle per operand. The block takes exactly the number of extension words the mode needs, and only on cycles where `ext_valid` and `ext_ready` are both high. Outputs hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operand while idle |
| ea_field | input | 6 | Mode (5:3) and register (2:0) |
| op_size | input | 2 | 0 byte, 1 word, 2 long |
| addr_only | input | 1 | Address-only use (reject non-memory forms) |
| is_dest | input | 1 | Operand is a write destination |
| pc_in | input | 32 | Address of the first extension word |
| rf_idx | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data (same cycle) |
| ext_valid | input | 1 | Extension word available |
| ext_word | input | 16 | Extension word |
| ext_ready | output | 1 | Block accepts an extension word |
| done | output | 1 | One-cycle completion pulse |
| ea_result | output | 32 | Address, immediate or register value |
| wb_en | output | 1 | Address-register write-back requested |
| wb_reg | output | 4 | Register-file index to write back |
| wb_val | output | 32 | Write-back value |
| extra_cycles | output | 5 | Added cycle cost |
| illegal | output | 1 | Field rejected |

## Verification
The bench targets the step exceptions first. A design that ignores the stack-pointer rule moves A7 by 1 on a byte access. A design that swaps the post-increment and pre-decrement ordering returns the updated value as the post-increment address. Brief words with a negative displacement and a word index whose bit 15 is set catch missing sign extension; such a design lands 64 KiB or 256 bytes away from the right address. Absolute-long and long-immediate cases catch swapped halves. The bench also counts the words each operand takes, under random stalls on `ext_valid`. A design that fetches too few or too many words, or skips the rejection of destination immediates and of address-only auto-increment, shows up as a wrong word count or a wrong `illegal` flag.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int AW  = 32;  // address / data width
  localparam int EW  = 16;  // extension word width
  localparam int CW  = 5;   // cycle-cost width
  localparam int RIW = 4;   // register-file index width

  typedef enum logic [3:0] {
    K_DREG, K_AREG, K_IND, K_POST, K_PRE, K_DISP, K_INDEX,
    K_ABSW, K_ABSL, K_PCDISP, K_PCINDEX, K_IMM, K_BAD
  } ea_kind_e;

  function automatic logic [AW-1:0] sx16(input logic [EW-1:0] w);
    return {{(AW-EW){w[EW-1]}}, w};
  endfunction

  function automatic logic [AW-1:0] sx8(input logic [7:0] b);
    return {{(AW-8){b[7]}}, b};
  endfunction

  // Step in bytes; byte through the stack register moves by two
  function automatic logic [2:0] step_bytes(input logic [1:0] sz, input logic [2:0] rn);
    logic [2:0] s;
    case (sz)
      2'd0:    s = (rn == 3'd7) ? 3'd2 : 3'd1;
      2'd1:    s = 3'd2;
      default: s = 3'd4;
    endcase
    return s;
  endfunction

  function automatic logic [CW-1:0] cost(input ea_kind_e k, input logic lng);
    logic [CW-1:0] c;
    case (k)
      K_IND, K_POST, K_IMM:       c = 5'd4;
      K_PRE:                      c = 5'd6;
      K_DISP, K_ABSW, K_PCDISP:   c = 5'd8;
      K_INDEX, K_PCINDEX:         c = 5'd10;
      K_ABSL:                     c = 5'd12;
      default:                    c = 5'd0;
    endcase
    if (c != 5'd0 && lng) c = c + 5'd4;
    return c;
  endfunction

  // base + (word or long index) + signed 8-bit displacement
  function automatic logic [AW-1:0] brief_addr(input logic [AW-1:0] base,
                                               input logic [EW-1:0] brief,
                                               input logic [AW-1:0] ixv);
    logic [AW-1:0] ix;
    ix = brief[11] ? ixv : sx16(ixv[EW-1:0]);
    return base + ix + sx8(brief[7:0]);
  endfunction
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [5:0] field,
  input  logic       addr_only,
  input  logic       is_dest,
  output ea_kind_e   kind,
  output logic       reject
);
  always_comb begin
    case (field[5:3])
      3'd0: kind = K_DREG;
      3'd1: kind = K_AREG;
      3'd2: kind = K_IND;
      3'd3: kind = K_POST;
      3'd4: kind = K_PRE;
      3'd5: kind = K_DISP;
      3'd6: kind = K_INDEX;
      default: begin
        case (field[2:0])
          3'd0:    kind = K_ABSW;
          3'd1:    kind = K_ABSL;
          3'd2:    kind = K_PCDISP;
          3'd3:    kind = K_PCINDEX;
          3'd4:    kind = K_IMM;
          default: kind = K_BAD;
        endcase
      end
    endcase
  end

  logic no_addr_form;
  assign no_addr_form = (kind == K_DREG) || (kind == K_AREG) || (kind == K_POST) ||
                        (kind == K_PRE)  || (kind == K_IMM);
  assign reject = (kind == K_BAD) || (is_dest && kind == K_IMM) ||
                  (addr_only && no_addr_form);
endmodule

// File: rtl/ea_autoinc.sv
module ea_autoinc
  import ea_pkg::*;
(
  input  ea_kind_e      kind,
  input  logic [AW-1:0] reg_val,
  input  logic [1:0]    sz,
  input  logic [2:0]    rnum,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] new_val,
  output logic          upd
);
  logic [AW-1:0] step;
  assign step = {{(AW-3){1'b0}}, step_bytes(sz, rnum)};

  always_comb begin
    addr    = reg_val;
    new_val = reg_val;
    upd     = 1'b0;
    if (kind == K_POST) begin
      new_val = reg_val + step;
      upd     = 1'b1;
    end else if (kind == K_PRE) begin
      addr    = reg_val - step;
      new_val = reg_val - step;
      upd     = 1'b1;
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [5:0]      ea_field,
  input  logic [1:0]      op_size,
  input  logic            addr_only,
  input  logic            is_dest,
  input  logic [AW-1:0]   pc_in,
  output logic [RIW-1:0]  rf_idx,
  input  logic [AW-1:0]   rf_data,
  input  logic            ext_valid,
  input  logic [EW-1:0]   ext_word,
  output logic            ext_ready,
  output logic            done,
  output logic [AW-1:0]   ea_result,
  output logic            wb_en,
  output logic [RIW-1:0]  wb_reg,
  output logic [AW-1:0]   wb_val,
  output logic [CW-1:0]   extra_cycles,
  output logic            illegal
);
  typedef enum logic [2:0] {S_IDLE, S_DEC, S_EXT1, S_EXT2, S_IDX} st_e;
  st_e st;

  logic [5:0]    field_q;
  logic [1:0]    size_q;
  logic          ao_q, dst_q;
  logic [AW-1:0] pc_q, base_q;
  logic [EW-1:0] w1_q;

  ea_kind_e kind;
  logic     reject;
  ea_decode u_dec (
    .field(field_q), .addr_only(ao_q), .is_dest(dst_q),
    .kind(kind), .reject(reject)
  );

  logic [AW-1:0] ai_addr, ai_new;
  logic          ai_upd;
  ea_autoinc u_ai (
    .kind(kind), .reg_val(rf_data), .sz(size_q), .rnum(field_q[2:0]),
    .addr(ai_addr), .new_val(ai_new), .upd(ai_upd)
  );

  // Named events for the checker
  logic busy, xfer, fin, lng, need2, indexed;
  assign busy      = (st != S_IDLE);
  assign ext_ready = (st == S_EXT1) || (st == S_EXT2);
  assign xfer      = ext_ready && ext_valid;
  assign lng       = size_q[1];
  assign need2     = (kind == K_ABSL) || (kind == K_IMM && lng);
  assign indexed   = (kind == K_INDEX) || (kind == K_PCINDEX);

  always_comb begin
    case (st)
      S_DEC:   rf_idx = (kind == K_DREG || kind == K_AREG) ? field_q[3:0]
                                                           : {1'b1, field_q[2:0]};
      S_IDX:   rf_idx = w1_q[15:12];
      default: rf_idx = '0;
    endcase
  end

  // Completion values
  logic [AW-1:0] fin_ea, fin_wbv;
  logic          fin_wbe, fin_ill;
  always_comb begin
    fin     = 1'b0;
    fin_ea  = '0;
    fin_wbv = '0;
    fin_wbe = 1'b0;
    fin_ill = 1'b0;
    case (st)
      S_DEC: begin
        if (reject) begin
          fin = 1'b1; fin_ill = 1'b1;
        end else if (kind == K_DREG || kind == K_AREG) begin
          fin = 1'b1; fin_ea = rf_data;
        end else if (kind == K_IND || kind == K_POST || kind == K_PRE) begin
          fin = 1'b1; fin_ea = ai_addr; fin_wbv = ai_new; fin_wbe = ai_upd;
        end
      end
      S_EXT1: begin
        if (xfer && !need2 && !indexed) begin
          fin = 1'b1;
          case (kind)
            K_DISP, K_PCDISP: fin_ea = base_q + sx16(ext_word);
            K_ABSW:           fin_ea = sx16(ext_word);
            default:          fin_ea = (size_q == 2'd0) ? sx8(ext_word[7:0]) : sx16(ext_word);
          endcase
        end
      end
      S_EXT2: begin
        if (xfer) begin
          fin = 1'b1; fin_ea = {w1_q, ext_word};
        end
      end
      S_IDX: begin
        fin = 1'b1; fin_ea = brief_addr(base_q, w1_q, rf_data);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      field_q      <= '0;
      size_q       <= '0;
      ao_q         <= 1'b0;
      dst_q        <= 1'b0;
      pc_q         <= '0;
      base_q       <= '0;
      w1_q         <= '0;
      done         <= 1'b0;
      ea_result    <= '0;
      wb_en        <= 1'b0;
      wb_reg       <= '0;
      wb_val       <= '0;
      extra_cycles <= '0;
      illegal      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          field_q <= ea_field;
          size_q  <= op_size;
          ao_q    <= addr_only;
          dst_q   <= is_dest;
          pc_q    <= pc_in;
          st      <= S_DEC;
        end
        S_DEC: if (!fin) begin
          base_q <= (kind == K_PCDISP || kind == K_PCINDEX) ? pc_q : rf_data;
          st     <= S_EXT1;
        end
        S_EXT1: if (xfer && !fin) begin
          w1_q <= ext_word;
          st   <= need2 ? S_EXT2 : S_IDX;
        end
        default: ;
      endcase
      if (fin) begin
        st           <= S_IDLE;
        done         <= 1'b1;
        ea_result    <= fin_ea;
        wb_en        <= fin_wbe;
        wb_reg       <= {1'b1, field_q[2:0]};
        wb_val       <= fin_wbv;
        extra_cycles <= fin_ill ? '0 : cost(kind, lng);
        illegal      <= fin_ill;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           busy,
  input logic           ext_ready,
  input logic           illegal,
  input logic           wb_en,
  input logic [RIW-1:0] wb_reg,
  input logic [CW-1:0]  extra_cycles,
  input logic [AW-1:0]  ea_result
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(ea_result) && $stable(wb_en) && $stable(illegal)));
  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> busy);
  // R10
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!wb_en && extra_cycles == '0 && ea_result == '0));
  // R2
  wb_areg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en) |-> wb_reg[3]);
  // R9
  wb_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en) |-> (extra_cycles >= 5'd4));
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .ext_ready(ext_ready),
  .illegal(illegal), .wb_en(wb_en), .wb_reg(wb_reg),
  .extra_cycles(extra_cycles), .ea_result(ea_result)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  ea_field = '0;
  logic [1:0]  op_size = '0;
  logic        addr_only = 1'b0;
  logic        is_dest = 1'b0;
  logic [31:0] pc_in = '0;
  logic [3:0]  rf_idx;
  logic [31:0] rf_data;
  logic        ext_valid = 1'b0;
  logic [15:0] ext_word = '0;
  logic        ext_ready, done, wb_en, illegal;
  logic [31:0] ea_result, wb_val;
  logic [3:0]  wb_reg;
  logic [4:0]  extra_cycles;

  logic [31:0] regs [16];
  assign rf_data = regs[rf_idx];

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  ea_gen dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input logic [15:0] w);
    return 32'(signed'(w));
  endfunction
  function automatic logic [31:0] sb(input logic [7:0] b);
    return 32'(signed'(b));
  endfunction

  // Independent reference model of the requirements
  task automatic model(input logic [5:0] f, input logic [1:0] sz, input bit ao, input bit wr,
                       input logic [15:0] wa, input logic [15:0] wbw, input logic [31:0] pc,
                       output logic [31:0] e, output bit we, output logic [31:0] wv,
                       output int cyc, output bit ill, output int nw, output string req);
    int grp; int rn; int stp; bit lg; logic [31:0] an; logic [31:0] ix;
    grp = int'(f) / 8; rn = int'(f) % 8; lg = (sz == 2'd2);
    an = regs[8 + rn];
    e = 0; we = 0; wv = 0; cyc = 0; nw = 0; ill = 0; req = "R1";
    stp = (sz == 0) ? ((rn == 7) ? 2 : 1) : (sz == 1 ? 2 : 4);
    if (f > 6'h3C || (wr && f == 6'h3C) ||
        (ao && (f < 6'h10 || (f >= 6'h18 && f < 6'h28) || f == 6'h3C))) begin
      ill = 1; req = "R10"; return;
    end
    if (grp <= 1) begin e = regs[f[3:0]]; req = "R1"; return; end
    if (grp == 2) begin e = an; cyc = lg ? 8 : 4; req = "R2"; return; end
    if (grp == 3) begin e = an; we = 1; wv = an + stp; cyc = lg ? 8 : 4; req = (rn == 7 && sz == 0) ? "R3" : "R2"; return; end
    if (grp == 4) begin e = an - stp; we = 1; wv = e; cyc = lg ? 10 : 6; req = (rn == 7 && sz == 0) ? "R3" : "R2"; return; end
    if (grp == 5) begin e = an + sw(wa); nw = 1; cyc = lg ? 12 : 8; req = "R4"; return; end
    if (grp == 6 || f == 6'h3B) begin
      ix = regs[wa[15:12]];
      if (!wa[11]) ix = sw(ix[15:0]);
      e = ((grp == 6) ? an : pc) + ix + sb(wa[7:0]);
      nw = 1; cyc = lg ? 14 : 10; req = "R5"; return;
    end
    case (f)
      6'h38: begin e = sw(wa); nw = 1; cyc = lg ? 12 : 8; req = "R6"; end
      6'h39: begin e = {wa, wbw}; nw = 2; cyc = lg ? 16 : 12; req = "R6"; end
      6'h3A: begin e = pc + sw(wa); nw = 1; cyc = lg ? 12 : 8; req = "R7"; end
      default: begin
        req = "R8"; cyc = lg ? 8 : 4;
        if (lg) begin e = {wa, wbw}; nw = 2; end
        else begin e = (sz == 0) ? sb(wa[7:0]) : sw(wa); nw = 1; end
      end
    endcase
  endtask

  task automatic run_op(input logic [5:0] f, input logic [1:0] sz, input bit ao, input bit wr,
                        input logic [15:0] wa, input logic [15:0] wbw, input logic [31:0] pc);
    logic [31:0] e, wv; bit we, ill; int cyc, nw, taken, waited; string req;
    logic [15:0] wl [2];
    model(f, sz, ao, wr, wa, wbw, pc, e, we, wv, cyc, ill, nw, req);
    wl[0] = wa; wl[1] = wbw; taken = 0; waited = 0;
    @(negedge clk);
    ea_field = f; op_size = sz; addr_only = ao; is_dest = wr; pc_in = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waited < 60) begin
      ext_valid = (($urandom % 3) != 0) && (taken < nw);
      ext_word  = wl[taken < 2 ? taken : 1];
      if (ext_valid && ext_ready) taken++;
      @(negedge clk);
      waited++;
    end
    ext_valid = 1'b0;
    check(done === 1'b1, "R11", 32'(done), 32'd1);
    check(ea_result === e, req, ea_result, e);
    check(illegal === ill, "R10", 32'(illegal), 32'(ill));
    check(wb_en === we, "R2", 32'(wb_en), 32'(we));
    if (we) begin
      check(wb_val === wv, (sz == 0 && f[2:0] == 3'd7) ? "R3" : "R2", wb_val, wv);
      check(wb_reg === {1'b1, f[2:0]}, "R2", 32'(wb_reg), 32'({1'b1, f[2:0]}));
    end
    check(int'(extra_cycles) == cyc, "R9", 32'(extra_cycles), 32'(cyc));
    check(taken == nw, "R11", 32'(taken), 32'(nw));
    @(negedge clk);
    check(done === 1'b0, "R11", 32'(done), 32'd0);
    check(ea_result === e, "R11", ea_result, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R11 actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 * i + 32'h10 * i;
    repeat (3) @(negedge clk);
    // reset state
    check(done === 1'b0 && ext_ready === 1'b0, "R11", 32'({done, ext_ready}), 32'd0);
    check(illegal === 1'b0 && wb_en === 1'b0, "R10", 32'({illegal, wb_en}), 32'd0);
    rst_n = 1'b1;

    regs[15] = 32'h0000_1000; run_op(6'h1F, 2'd0, 0, 0, 0, 0, 0);               // R3 post-inc A7 byte
    regs[11] = 32'h0000_2000; run_op(6'h23, 2'd0, 0, 0, 0, 0, 0);               // R2 pre-dec byte step 1
    run_op(6'h27, 2'd0, 0, 0, 0, 0, 0);                                         // R3 pre-dec A7 byte
    regs[10] = 32'h0000_8000; regs[3] = 32'h0001_FFFF;
    run_op(6'h32, 2'd1, 0, 0, 16'h30FE, 0, 0);                                  // R5 word index, neg disp
    run_op(6'h39, 2'd2, 0, 0, 16'h1234, 16'h5678, 0);                           // R6 absolute long
    run_op(6'h38, 2'd1, 0, 0, 16'h8001, 0, 0);                                  // R6 absolute short
    regs[8] = 32'h0000_0100; run_op(6'h3B, 2'd0, 0, 0, 16'h8810, 0, 32'h400);   // R5 PC index, long
    run_op(6'h3A, 2'd1, 0, 0, 16'hFFFE, 0, 32'h0000_0800);                      // R7
    run_op(6'h3C, 2'd2, 0, 0, 16'hDEAD, 16'hBEEF, 0);                           // R8 long imm
    run_op(6'h3C, 2'd0, 0, 0, 16'h1280, 0, 0);                                  // R8 byte imm
    run_op(6'h3D, 2'd1, 0, 0, 0, 0, 0);                                         // R10 beyond range
    run_op(6'h3C, 2'd1, 0, 1, 16'h1111, 0, 0);                                  // R10 imm dest
    run_op(6'h18, 2'd1, 1, 0, 0, 0, 0);                                         // R10 address-only
    regs[8] = 32'h0001_0000; run_op(6'h28, 2'd1, 1, 0, 16'h8000, 0, 0);         // R4 address-only ok
    run_op(6'h05, 2'd2, 0, 0, 0, 0, 0);                                         // R1 data reg
    run_op(6'h0E, 2'd1, 0, 0, 0, 0, 0);                                         // R1 address reg

    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < 16; i++) regs[i] = $urandom;
      run_op(6'($urandom), 2'($urandom % 3), ($urandom % 8) == 0, ($urandom % 8) == 0,
             16'($urandom), 16'($urandom), $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule